// File: doc/BRIEF.md
# Operand Effective Address Sequencer

This block sits between instruction decode and a single-port word memory. Once decode has an instruction word and knows its addressing form, it pulses `start`. The sequencer then runs whatever reads and writes the form needs to produce the operand's 15-bit word address and its 16-bit value. The block also owns the program counter: it steps past the instruction word and past any extension word it consumes, and it loads a pin-selected vector at reset.

There are four operand forms, selected by a 2-bit mode:

- **Short form.** An 11-bit constant is carried in the instruction. A zero field means the operand is instead the word after the instruction.
- **Zero-page pointer.** The low byte of the instruction selects a pointer word in the zero page.
- **Stepping pointer.** Like the zero-page pointer, but the pointer is pre-incremented or post-decremented and written back to memory.
- **Indirect.** The word after the instruction is the pointer.

Zero-page word 0 is reserved for the stack pointer. Selecting it as a pointer raises a fault without touching memory.

Memory traffic uses a request/acknowledge pair. Only one access is outstanding at a time, and each request is held until it is acknowledged. Completion is reported by a one-cycle `done` pulse. A new `start` is accepted in that same cycle, so instructions can be issued back to back.

Top module: `opnd_addr_seq`

## Requirements
- R1: While `rstN` is low, `pcOut` loads 0x4000 if `addrSel` is 0 and 0x0800 if `addrSel` is 1. After reset, `ready` is 1 and `done`, `fault` and `memReq` are 0.
- R2: When `start` is accepted, `opCode` takes bits 15:12 of `instrWord` and holds them until the next accepted `start`.
- R3: Mode 00 with bits 10:0 non-zero makes no memory access. The cycle after acceptance shows `done`, with `opndVal` and `opndAddr` both equal to the zero-extended field and `pcOut` equal to its old value plus 1.
- R4: Mode 00 with bits 10:0 zero performs one read at old PC + 1. `opndAddr` is that address, `opndVal` is the data read, and `pcOut` becomes old PC + 2.
- R5: Mode 01 reads the zero-page word at bits 7:0. It then reads the operand at the low 15 bits of that word. It makes no write, and `pcOut` becomes old PC + 1.
- R6: Mode 10 with `stepDown`=0 does three accesses in order: it reads pointer p, writes p+1 back to the same zero-page word, then reads the operand at p+1.
- R7: Mode 10 with `stepDown`=1 does three accesses in order: it reads pointer p, reads the operand at p, then writes p-1 back to the zero-page word.
- R8: Mode 11 reads a pointer at old PC + 1, then reads the operand at that pointer's low 15 bits. `pcOut` becomes old PC + 2.
- R9: In mode 01 or 10 with bits 7:0 all zero, the block raises `fault` for one cycle with no memory request and no `done`, and leaves `pcOut` unchanged.
- R10: A request holds `memReq`, `memAddr`, `memWe` and `memWdata` stable until `memAck`. `memWe` is 1 only on a pointer write-back.
- R11: `start` is ignored while `ready` is 0. It is accepted in the cycle `done` is high.
- R12: `done` is high for a single cycle per instruction and never while `memReq` is high, so every write-back has finished before `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| addrSel | input | 1 | Reset vector select: 0 gives 0x4000, 1 gives 0x0800 |
| start | input | 1 | Begin operand fetch for `instrWord` |
| instrWord | input | 16 | Instruction word |
| modeIn | input | 2 | 00 short, 01 zero-page pointer, 10 stepping pointer, 11 indirect |
| stepDown | input | 1 | For mode 10: 0 pre-increment, 1 post-decrement |
| ready | output | 1 | Sequencer can accept `start` |
| done | output | 1 | Operand results valid (one-cycle pulse) |
| fault | output | 1 | Zero-page index 0 was selected (one-cycle pulse) |
| opCode | output | 4 | Operation code passed through from bits 15:12 |
| opndAddr | output | 15 | Operand word address |
| opndVal | output | 16 | Operand value |
| pcOut | output | 15 | Program counter |
| memReq | output | 1 | Memory access request |
| memWe | output | 1 | Access is a write |
| memAddr | output | 15 | Memory word address |
| memWdata | output | 16 | Write data (updated pointer) |
| memAck | input | 1 | Memory acknowledge; read data valid in the same cycle |
| memRdata | input | 16 | Memory read data |

## Verification
Two things can fall in the same cycle: the completion of one instruction and the acceptance of the next. The bench holds `start` high through a `done` cycle with a second instruction on the inputs. It then checks that `done` reappears on the next cycle carrying the second instruction's operation code and operand, and that the program counter has advanced by both instructions. A related collision, `start` arriving while a pointer read is still pending, is provoked mid-sequence. That case is judged by checking that the results and the access count belong only to the first instruction.

// File: rtl/opseq_pkg.sv
package opseq_pkg;

  typedef enum logic [1:0] {
    MODE_SHORT = 2'b00,
    MODE_ZPTR  = 2'b01,
    MODE_ZSTEP = 2'b10,
    MODE_XIND  = 2'b11
  } modeT;

  typedef enum logic [1:0] {
    SRC_NONE,
    SRC_PC,
    SRC_IDX,
    SRC_PTR
  } srcT;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_EXT,
    ST_PTR,
    ST_PWR,
    ST_OPND,
    ST_FIN,
    ST_FLT
  } stateT;

  // control-to-datapath strobes
  typedef struct packed {
    logic latchIn;
    logic pcStep;
    logic capConst;
    logic capPtr;
    logic commitPtr;
    logic capOpnd;
    srcT  addrSrc;
  } strobeT;

endpackage

// File: rtl/opseq_dp.sv
module opseq_dp
  import opseq_pkg::*;
#(
  parameter int AW = 15,
  parameter int DW = 16,
  parameter int OPW = 4,
  parameter int SHORTW = 11,
  parameter int IDXW = 8,
  parameter logic [AW-1:0] VEC_LO = 15'h4000,
  parameter logic [AW-1:0] VEC_HI = 15'h0800
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           addrSel,
  input  logic [DW-1:0]  instrWord,
  input  logic           stepDown,
  input  strobeT         stb,
  input  logic [DW-1:0]  memRdata,
  output logic           shortZero,
  output logic           idxZero,
  output logic [AW-1:0]  memAddr,
  output logic [DW-1:0]  memWdata,
  output logic [OPW-1:0] opCode,
  output logic [AW-1:0]  opndAddr,
  output logic [DW-1:0]  opndVal,
  output logic [AW-1:0]  pcOut
);

  localparam int SPAREW = DW - OPW - SHORTW;

  logic [AW-1:0]   pcReg;
  logic [OPW-1:0]  opReg;
  logic [IDXW-1:0] idxReg;
  logic            dirReg;
  logic [DW-1:0]   ptrReg;
  logic [AW-1:0]   addrReg;
  logic [DW-1:0]   valReg;
  logic [DW-1:0]   stepped;

  // the mode bits between opcode and short field are decoded upstream
  logic [SPAREW-1:0] unusedSpare;
  assign unusedSpare = instrWord[DW-OPW-1:SHORTW];

  assign shortZero = (instrWord[SHORTW-1:0] == '0);
  assign idxZero   = (instrWord[IDXW-1:0] == '0);

  assign stepped = dirReg ? (ptrReg - DW'(1)) : (ptrReg + DW'(1));

  always_comb begin
    case (stb.addrSrc)
      SRC_PC:  memAddr = pcReg;
      SRC_IDX: memAddr = AW'(idxReg);
      SRC_PTR: memAddr = ptrReg[AW-1:0];
      default: memAddr = '0;
    endcase
  end

  assign memWdata = stepped;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pcReg   <= addrSel ? VEC_HI : VEC_LO;
      opReg   <= '0;
      idxReg  <= '0;
      dirReg  <= 1'b0;
      ptrReg  <= '0;
      addrReg <= '0;
      valReg  <= '0;
    end else begin
      if (stb.latchIn) begin
        opReg  <= instrWord[DW-1 -: OPW];
        idxReg <= instrWord[IDXW-1:0];
        dirReg <= stepDown;
      end
      if (stb.pcStep) pcReg <= pcReg + AW'(1);
      if (stb.capConst) begin
        addrReg <= AW'(instrWord[SHORTW-1:0]);
        valReg  <= DW'(instrWord[SHORTW-1:0]);
      end
      if (stb.capPtr)    ptrReg <= memRdata;
      if (stb.commitPtr) ptrReg <= stepped;
      if (stb.capOpnd) begin
        addrReg <= memAddr;
        valReg  <= memRdata;
      end
    end
  end

  assign opCode   = opReg;
  assign opndAddr = addrReg;
  assign opndVal  = valReg;
  assign pcOut    = pcReg;

endmodule

// File: rtl/opseq_ctl.sv
module opseq_ctl
  import opseq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [1:0] modeIn,
  input  logic       stepDown,
  input  logic       shortZero,
  input  logic       idxZero,
  input  logic       memAck,
  output strobeT     stb,
  output logic       memReq,
  output logic       memWe,
  output logic       ready,
  output logic       done,
  output logic       fault
);

  stateT state, nextState;
  modeT  modeReg;
  logic  dirReg;
  logic  accept;

  assign ready  = (state == ST_IDLE) || (state == ST_FIN) || (state == ST_FLT);
  assign done   = (state == ST_FIN);
  assign fault  = (state == ST_FLT);
  assign accept = start && ready;
  assign memReq = (state == ST_EXT) || (state == ST_PTR) ||
                  (state == ST_PWR) || (state == ST_OPND);
  assign memWe  = (state == ST_PWR);

  always_comb begin
    stb       = '0;
    stb.addrSrc = SRC_NONE;
    nextState = state;
    case (state)
      ST_IDLE, ST_FIN, ST_FLT: begin
        nextState = ST_IDLE;
        if (accept) begin
          stb.latchIn = 1'b1;
          case (modeT'(modeIn))
            MODE_SHORT: begin
              stb.pcStep = 1'b1;
              if (shortZero) nextState = ST_EXT;
              else begin
                stb.capConst = 1'b1;
                nextState    = ST_FIN;
              end
            end
            MODE_ZPTR, MODE_ZSTEP: begin
              if (idxZero) nextState = ST_FLT;
              else begin
                stb.pcStep = 1'b1;
                nextState  = ST_PTR;
              end
            end
            default: begin
              stb.pcStep = 1'b1;
              nextState  = ST_EXT;
            end
          endcase
        end
      end
      ST_EXT: begin
        stb.addrSrc = SRC_PC;
        if (memAck) begin
          stb.pcStep = 1'b1;
          if (modeReg == MODE_SHORT) begin
            stb.capOpnd = 1'b1;
            nextState   = ST_FIN;
          end else begin
            stb.capPtr = 1'b1;
            nextState  = ST_OPND;
          end
        end
      end
      ST_PTR: begin
        stb.addrSrc = SRC_IDX;
        if (memAck) begin
          stb.capPtr = 1'b1;
          nextState  = (modeReg == MODE_ZSTEP && !dirReg) ? ST_PWR : ST_OPND;
        end
      end
      ST_PWR: begin
        stb.addrSrc = SRC_IDX;
        if (memAck) begin
          if (!dirReg) begin
            stb.commitPtr = 1'b1;
            nextState     = ST_OPND;
          end else begin
            nextState = ST_FIN;
          end
        end
      end
      ST_OPND: begin
        stb.addrSrc = SRC_PTR;
        if (memAck) begin
          stb.capOpnd = 1'b1;
          nextState   = (modeReg == MODE_ZSTEP && dirReg) ? ST_PWR : ST_FIN;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      modeReg <= MODE_SHORT;
      dirReg  <= 1'b0;
    end else begin
      state <= nextState;
      if (stb.latchIn) begin
        modeReg <= modeT'(modeIn);
        dirReg  <= stepDown;
      end
    end
  end

endmodule

// File: rtl/opnd_addr_seq.sv
module opnd_addr_seq
  import opseq_pkg::*;
#(
  parameter int AW = 15,
  parameter int DW = 16,
  parameter int OPW = 4,
  parameter int SHORTW = 11,
  parameter int IDXW = 8,
  parameter logic [AW-1:0] VEC_LO = 15'h4000,
  parameter logic [AW-1:0] VEC_HI = 15'h0800
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           addrSel,
  input  logic           start,
  input  logic [DW-1:0]  instrWord,
  input  logic [1:0]     modeIn,
  input  logic           stepDown,
  output logic           ready,
  output logic           done,
  output logic           fault,
  output logic [OPW-1:0] opCode,
  output logic [AW-1:0]  opndAddr,
  output logic [DW-1:0]  opndVal,
  output logic [AW-1:0]  pcOut,
  output logic           memReq,
  output logic           memWe,
  output logic [AW-1:0]  memAddr,
  output logic [DW-1:0]  memWdata,
  input  logic           memAck,
  input  logic [DW-1:0]  memRdata
);

  strobeT stb;
  logic   shortZero;
  logic   idxZero;

  opseq_ctl u_ctl (
    .clk(clk), .rstN(rstN), .start(start), .modeIn(modeIn),
    .stepDown(stepDown), .shortZero(shortZero), .idxZero(idxZero),
    .memAck(memAck), .stb(stb), .memReq(memReq), .memWe(memWe),
    .ready(ready), .done(done), .fault(fault)
  );

  opseq_dp #(
    .AW(AW), .DW(DW), .OPW(OPW), .SHORTW(SHORTW), .IDXW(IDXW),
    .VEC_LO(VEC_LO), .VEC_HI(VEC_HI)
  ) u_dp (
    .clk(clk), .rstN(rstN), .addrSel(addrSel), .instrWord(instrWord),
    .stepDown(stepDown), .stb(stb), .memRdata(memRdata),
    .shortZero(shortZero), .idxZero(idxZero), .memAddr(memAddr),
    .memWdata(memWdata), .opCode(opCode), .opndAddr(opndAddr),
    .opndVal(opndVal), .pcOut(pcOut)
  );

endmodule

// File: rtl/opseq_chk.sv
module opseq_chk #(
  parameter int AW = 15,
  parameter int DW = 16,
  parameter int OPW = 4
) (
  input logic           clk,
  input logic           rstN,
  input logic           start,
  input logic           ready,
  input logic           done,
  input logic           fault,
  input logic [OPW-1:0] opCode,
  input logic           memReq,
  input logic           memWe,
  input logic [AW-1:0]  memAddr,
  input logic [DW-1:0]  memWdata,
  input logic           memAck
);

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memAddr) && $stable(memWe) && $stable(memWdata)));

  // R10
  we_in_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> memReq);

  // R12
  done_idle_bus_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !memReq);

  // R9
  fault_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    fault |-> (!memReq && !done));

  // R11
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && !ready) |=> $stable(opCode));

  // R12
  done_flag_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(done && fault));

endmodule

bind opnd_addr_seq opseq_chk #(.AW(AW), .DW(DW), .OPW(OPW)) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .ready(ready), .done(done),
  .fault(fault), .opCode(opCode), .memReq(memReq), .memWe(memWe),
  .memAddr(memAddr), .memWdata(memWdata), .memAck(memAck)
);

// File: tb/sim_opnd_addr_seq.sv
module sim_opnd_addr_seq;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        addrSel = 1'b0;
  logic        start = 1'b0;
  logic [15:0] instrWord = '0;
  logic [1:0]  modeIn = '0;
  logic        stepDown = 1'b0;
  logic        ready, done, fault;
  logic [3:0]  opCode;
  logic [14:0] opndAddr;
  logic [15:0] opndVal;
  logic [14:0] pcOut;
  logic        memReq, memWe;
  logic [14:0] memAddr;
  logic [15:0] memWdata;
  logic        memAck = 1'b0;
  logic [15:0] memRdata = '0;

  int total = 0;
  int bad = 0;
  int lat = 0;
  int waitCnt = 0;
  int nAcc = 0;
  logic [14:0] logA [16];
  logic        logW [16];
  logic [15:0] logD [16];

  always #2 clk = ~clk;

  opnd_addr_seq u0 (
    .clk(clk), .rstN(rstN), .addrSel(addrSel), .start(start),
    .instrWord(instrWord), .modeIn(modeIn), .stepDown(stepDown),
    .ready(ready), .done(done), .fault(fault), .opCode(opCode),
    .opndAddr(opndAddr), .opndVal(opndVal), .pcOut(pcOut),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata), .memAck(memAck), .memRdata(memRdata)
  );

  function automatic logic [15:0] memF(input logic [14:0] a);
    return (16'({1'b0, a}) * 16'd29) ^ 16'h2C51;
  endfunction

  // memory responder with programmable wait
  always @(posedge clk) begin
    if (!rstN) begin
      memAck  <= 1'b0;
      waitCnt <= 0;
    end else begin
      memAck <= 1'b0;
      if (memReq && !memAck) begin
        if (waitCnt >= lat) begin
          memAck          <= 1'b1;
          memRdata        <= memF(memAddr);
          logA[nAcc % 16] <= memAddr;
          logW[nAcc % 16] <= memWe;
          logD[nAcc % 16] <= memWdata;
          nAcc            <= nAcc + 1;
          waitCnt         <= 0;
        end else begin
          waitCnt <= waitCnt + 1;
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  task automatic issue(input logic [15:0] iw, input logic [1:0] m, input logic d);
    int k;
    start = 1'b1; instrWord = iw; modeIn = m; stepDown = d;
    @(negedge clk);
    start = 1'b0;
    k = 0;
    while (!(done || fault) && k < 200) begin
      @(negedge clk);
      k++;
    end
  endtask

  task automatic doReset(input logic sel, input logic [14:0] vec);
    rstN = 1'b0; addrSel = sel;
    repeat (3) @(negedge clk);
    chk("R1 vector in reset", 32'(pcOut), 32'(vec));
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 vector after reset", 32'(pcOut), 32'(vec));
    chk("R1 idle flags", {ready, done, fault, memReq}, 4'b1000);
  endtask

  task automatic tShort();
    logic [14:0] pc0 = pcOut;
    int b = nAcc;
    lat = 0;
    issue(16'h92A5, 2'b00, 1'b0);
    chk("R3 done", 32'(done), 1);
    chk("R2 opcode", 32'(opCode), 4'h9);
    chk("R3 value", 32'(opndVal), 16'h02A5);
    chk("R3 addr", 32'(opndAddr), 15'h02A5);
    chk("R3 pc", 32'(pcOut), 32'(15'(pc0 + 15'd1)));
    chk("R3 no access", nAcc - b, 0);
    chk("R12 no request at done", 32'(memReq), 0);
    @(negedge clk);
    chk("R12 done single", 32'(done), 0);
  endtask

  task automatic tExtWord();
    logic [14:0] pc0 = pcOut;
    logic [14:0] ea = 15'(pc0 + 15'd1);
    int b = nAcc;
    lat = 2;
    issue(16'h9000, 2'b00, 1'b0);
    chk("R4 done", 32'(done), 1);
    chk("R4 accesses", nAcc - b, 1);
    chk("R4 read addr", 32'(logA[b % 16]), 32'(ea));
    chk("R4 value", 32'(opndVal), 32'(memF(ea)));
    chk("R4 addr", 32'(opndAddr), 32'(ea));
    chk("R4 pc", 32'(pcOut), 32'(15'(pc0 + 15'd2)));
  endtask

  task automatic tPointer();
    logic [14:0] pc0 = pcOut;
    logic [15:0] p = memF(15'h0037);
    int b = nAcc;
    lat = 1;
    issue(16'h5037, 2'b01, 1'b0);
    chk("R5 accesses", nAcc - b, 2);
    chk("R5 ptr addr", 32'(logA[b % 16]), 32'h37);
    chk("R5 opnd addr", 32'(logA[(b + 1) % 16]), 32'(p[14:0]));
    chk("R5 no write", 32'({logW[b % 16], logW[(b + 1) % 16]}), 0);
    chk("R5 value", 32'(opndVal), 32'(memF(p[14:0])));
    chk("R5 addr", 32'(opndAddr), 32'(p[14:0]));
    chk("R5 pc", 32'(pcOut), 32'(15'(pc0 + 15'd1)));
    chk("R2 opcode", 32'(opCode), 4'h5);
  endtask

  task automatic tPreInc();
    logic [15:0] p = memF(15'h0012);
    logic [15:0] q = p + 16'd1;
    int b = nAcc;
    lat = 1;
    issue(16'hA412, 2'b10, 1'b0);
    chk("R6 accesses", nAcc - b, 3);
    chk("R6 first read idx", 32'({logW[b % 16], logA[b % 16]}), 32'h12);
    chk("R6 write idx", 32'({logW[(b + 1) % 16], logA[(b + 1) % 16]}), 32'h8012);
    chk("R6 write data", 32'(logD[(b + 1) % 16]), 32'(q));
    chk("R6 opnd read", 32'({logW[(b + 2) % 16], logA[(b + 2) % 16]}), 32'(q[14:0]));
    chk("R6 value", 32'(opndVal), 32'(memF(q[14:0])));
  endtask

  task automatic tPostDec();
    logic [15:0] p = memF(15'h00FE);
    int b = nAcc;
    lat = 3;
    issue(16'h72FE, 2'b10, 1'b1);
    chk("R7 accesses", nAcc - b, 3);
    chk("R7 first read idx", 32'({logW[b % 16], logA[b % 16]}), 32'hFE);
    chk("R7 opnd read", 32'({logW[(b + 1) % 16], logA[(b + 1) % 16]}), 32'(p[14:0]));
    chk("R7 write last", 32'({logW[(b + 2) % 16], logA[(b + 2) % 16]}), 32'h80FE);
    chk("R7 write data", 32'(logD[(b + 2) % 16]), 32'(16'(p - 16'd1)));
    chk("R7 value", 32'(opndVal), 32'(memF(p[14:0])));
    chk("R10 one write only", 32'({logW[b % 16], logW[(b + 1) % 16]}), 0);
    chk("R12 write done before done", 32'(memReq), 0);
  endtask

  task automatic tIndirect();
    logic [14:0] pc0 = pcOut;
    logic [14:0] ea = 15'(pc0 + 15'd1);
    logic [15:0] p = memF(ea);
    int b = nAcc;
    lat = 0;
    issue(16'hC800, 2'b11, 1'b0);
    chk("R8 accesses", nAcc - b, 2);
    chk("R8 ext read", 32'(logA[b % 16]), 32'(ea));
    chk("R8 opnd read", 32'(logA[(b + 1) % 16]), 32'(p[14:0]));
    chk("R8 value", 32'(opndVal), 32'(memF(p[14:0])));
    chk("R8 pc", 32'(pcOut), 32'(15'(pc0 + 15'd2)));
  endtask

  task automatic tFault(input logic [1:0] m);
    logic [14:0] pc0 = pcOut;
    int b = nAcc;
    issue(16'h5100, m, 1'b0);
    chk("R9 fault", {fault, done}, 2'b10);
    chk("R9 pc kept", 32'(pcOut), 32'(pc0));
    chk("R9 no access", nAcc - b, 0);
    @(negedge clk);
    chk("R9 fault single", 32'(fault), 0);
  endtask

  task automatic tBusy();
    logic [15:0] p = memF(15'h0037);
    int b = nAcc;
    int k = 0;
    lat = 2;
    start = 1'b1; instrWord = 16'h5037; modeIn = 2'b01; stepDown = 1'b0;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    chk("R11 busy", 32'(ready), 0);
    start = 1'b1; instrWord = 16'h3111; modeIn = 2'b00;
    @(negedge clk);
    start = 1'b0;
    while (!done && k < 200) begin
      @(negedge clk);
      k++;
    end
    chk("R11 opcode kept", 32'(opCode), 4'h5);
    chk("R11 value kept", 32'(opndVal), 32'(memF(p[14:0])));
    chk("R11 accesses", nAcc - b, 2);
    @(negedge clk);
    chk("R11 no late start", {done, ready}, 2'b01);
  endtask

  task automatic tBackToBack();
    logic [14:0] pc0 = pcOut;
    lat = 0;
    start = 1'b1; instrWord = 16'h1123; modeIn = 2'b00;
    @(negedge clk);
    chk("R12 first done", 32'(done), 1);
    chk("R11 first value", 32'(opndVal), 16'h0123);
    instrWord = 16'h2456;
    @(negedge clk);
    start = 1'b0;
    chk("R11 second done", 32'(done), 1);
    chk("R11 second opcode", 32'(opCode), 4'h2);
    chk("R11 second value", 32'(opndVal), 16'h0456);
    chk("R11 pc both", 32'(pcOut), 32'(15'(pc0 + 15'd2)));
    @(negedge clk);
    chk("R12 settles", 32'(done), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog R12 actual=hung expected=finished");
    finish();
  end

  initial begin
    @(negedge clk);
    doReset(1'b1, 15'h0800);
    doReset(1'b0, 15'h4000);
    tShort();
    tExtWord();
    tPointer();
    tPreInc();
    tPostDec();
    tIndirect();
    tFault(2'b01);
    tFault(2'b10);
    tBusy();
    tBackToBack();
    repeat (3) @(negedge clk);
    finish();
  end

endmodule